// File: doc/BRIEF.md
# Wake Pin Edge Sampler

This block watches an active-low external wake pin and reports a wake-up when the pin goes from high to low. The pin first passes through a two-flop synchroniser. It is then sampled by a strobe, and each strobe result is held in a register until the next strobe. A falling edge is a held sample of 1 followed by a new sample of 0.

The strobe comes from one of two sources. In continuous mode, a free-running divider fires every `TICK_DIV` clocks. In cyclic mode, the block drives a supply-enable output that is high for `ON_LEN` clocks in every period. The period is `SHORT_PERIOD` clocks, or twice that when the long period is selected. The pin is sampled once per window, `SETTLE` clocks after the window opens. Cyclic mode saves bias current in the external switches. When the supply is held on permanently, the block always samples continuously.

Each detected edge produces a one-cycle event pulse for the interrupt logic and sets a sticky edge flag. A status-read strobe clears the flag. A separate level flag shows the held sample.

Top module: `wake_edge_sampler`

## Requirements
- R1: An edge is recognised only when the held sample is 1 and the new sample is 0. A low-to-high change on the pin never sets the edge flag.
- R2: When `cont_mode_i` is 1, the pin is sampled every `TICK_DIV` clocks. A low level lasting at least `TICK_DIV+2` clocks is detected.
- R3: When `cont_mode_i` is 0 and `supply_hold_i` is 0, the pin is sampled only at window offset `SETTLE`. A low pulse that starts and ends between two such samples is not seen.
- R4: `sup_en_o` rises every `SHORT_PERIOD` clocks when `long_period_i` is 0, and every `2*SHORT_PERIOD` clocks when it is 1. Each time it rises, it stays high for `ON_LEN` clocks.
- R5: While `supply_hold_i` is 1, `sup_en_o` stays at 1 and sampling is continuous, whatever the value of `cont_mode_i`.
- R6: `level_o` shows the held sample. It is 0 while the pin is held low and has been sampled.
- R7: While `wake_en_i` is 0, no event pulse occurs and the edge flag is not set. The held sample follows the pin, so enabling the block later does not create a false edge.
- R8: `edge_flag_o` stays set until `stat_rd_i` is pulsed. A new edge in the same cycle as the read takes priority, and the flag stays set.
- R9: `wake_evt_o` is a one-clock pulse, issued exactly once for each detected edge.
- R10: After reset, `edge_flag_o` and `wake_evt_o` are 0, `level_o` is 1, and the cycle timer is at the start of a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_ni | input | 1 | External wake pin, active low, asynchronous |
| cont_mode_i | input | 1 | 1: continuous sampling; 0: cyclic sampling |
| wake_en_i | input | 1 | Enables wake detection |
| long_period_i | input | 1 | Selects the doubled cycle period |
| supply_hold_i | input | 1 | Switched supply is held on permanently |
| stat_rd_i | input | 1 | Status-read strobe; clears the edge flag |
| sup_en_o | output | 1 | Enable for the switched supply |
| edge_flag_o | output | 1 | Sticky falling-edge flag |
| level_o | output | 1 | Held sampled level of the pin |
| wake_evt_o | output | 1 | One-cycle wake event for the interrupt logic |

## Verification
The hardest case is cyclic mode, where a low pulse must fall entirely between two settle-offset samples so that it is missed. Without knowing the window phase, stimulus cannot place the pulse there. The bench locks to each rising edge of `sup_en_o`. It then starts the pulse after the window has closed and releases it well before the next sample point. For the detected case, it stretches the pulse across that sample point instead. The same alignment is reused with the supply held on, which shows that the identical pulse is now caught.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic {
    SRC_CYCLIC = 1'b0,
    SRC_CONT   = 1'b1
  } samp_src_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[g] <= 1'b1;
          else         sr_q[g] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[g] <= 1'b1;
          else         sr_q[g] <= sr_q[g-1];
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/wake_tick_gen.sv
module wake_tick_gen #(
  parameter int TICK_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;

  assign tick_o = (cnt_q == LAST);

  p_tick_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o || (TICK_DIV == 1));
endmodule

// File: rtl/wake_cycle_timer.sv
module wake_cycle_timer #(
  parameter int SHORT_PERIOD = 1600,
  parameter int ON_LEN       = 16,
  parameter int SETTLE       = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_i,
  output logic win_o,
  output logic settle_o
);
  localparam int LONG_PERIOD = 2 * SHORT_PERIOD;
  localparam int CW = $clog2(LONG_PERIOD);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_PERIOD - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = long_i ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q >= last) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;

  assign win_o    = (cnt_q < CW'(ON_LEN));
  assign settle_o = (cnt_q == CW'(SETTLE));

  p_settle_in_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settle_o |-> win_o);
  p_settle_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settle_o |=> !settle_o);
endmodule

// File: rtl/wake_edge_sampler.sv
module wake_edge_sampler
  import wake_pkg::*;
#(
  parameter int TICK_DIV     = 16,
  parameter int SHORT_PERIOD = 1600,
  parameter int ON_LEN       = 16,
  parameter int SETTLE       = 6,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_ni,
  input  logic cont_mode_i,
  input  logic wake_en_i,
  input  logic long_period_i,
  input  logic supply_hold_i,
  input  logic stat_rd_i,
  output logic sup_en_o,
  output logic edge_flag_o,
  output logic level_o,
  output logic wake_evt_o
);
  samp_src_e src;
  logic      pin_s, tick, win, settle, strobe;
  logic      held_q, evt_q, flag_q, edge_det;

  wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wake_ni),
    .q_o   (pin_s)
  );

  wake_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  wake_cycle_timer #(
    .SHORT_PERIOD(SHORT_PERIOD),
    .ON_LEN      (ON_LEN),
    .SETTLE      (SETTLE)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .long_i  (long_period_i),
    .win_o   (win),
    .settle_o(settle)
  );

  // held-on supply overrides the mode bit
  assign src    = (cont_mode_i || supply_hold_i) ? SRC_CONT : SRC_CYCLIC;
  assign strobe = (src == SRC_CONT) ? tick : settle;

  assign edge_det = wake_en_i && strobe && held_q && !pin_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        held_q <= 1'b1;
    else if (!wake_en_i) held_q <= pin_s;
    else if (strobe)    held_q <= pin_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      evt_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      evt_q <= edge_det;
      if (edge_det)       flag_q <= 1'b1;
      else if (stat_rd_i) flag_q <= 1'b0;
    end

  assign sup_en_o    = supply_hold_i || win;
  assign edge_flag_o = flag_q;
  assign level_o     = held_q;
  assign wake_evt_o  = evt_q;

  p_evt_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_evt_o |=> !wake_evt_o);
  p_evt_sets_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_evt_o |-> edge_flag_o);
  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_flag_o && !stat_rd_i) |=> edge_flag_o);
  p_no_evt_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wake_en_i)) |-> !wake_evt_o);
  p_hold_supply_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_hold_i |-> sup_en_o);
  p_evt_low_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_evt_o |-> !level_o);
endmodule

// File: tb/tb_wake_edge_sampler.sv
`timescale 1ns/1ps
module tb_wake_edge_sampler;
  localparam int TICK_DIV = 4;
  localparam int SHORT    = 32;
  localparam int ON_LEN   = 8;
  localparam int SETTLE   = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wake_ni = 1'b1;
  logic cont_mode_i = 1'b1;
  logic wake_en_i = 1'b1;
  logic long_period_i = 1'b0;
  logic supply_hold_i = 1'b0;
  logic stat_rd_i = 1'b0;
  logic sup_en_o, edge_flag_o, level_o, wake_evt_o;

  int checks = 0;
  int fails = 0;
  int evt_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  wake_edge_sampler #(
    .TICK_DIV(TICK_DIV), .SHORT_PERIOD(SHORT), .ON_LEN(ON_LEN), .SETTLE(SETTLE)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wake_ni(wake_ni), .cont_mode_i(cont_mode_i),
    .wake_en_i(wake_en_i), .long_period_i(long_period_i), .supply_hold_i(supply_hold_i),
    .stat_rd_i(stat_rd_i), .sup_en_o(sup_en_o), .edge_flag_o(edge_flag_o),
    .level_o(level_o), .wake_evt_o(wake_evt_o)
  );

  always @(negedge clk_i) if (wake_evt_o) evt_cnt++;

  typedef struct packed {
    logic       cont;
    logic       hold;
    logic       en;
    logic [7:0] low_len;
    logic       exp_edge;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 1'b1, 8'd10, 1'b1},
    '{1'b0, 1'b0, 1'b1, 8'd10, 1'b0},
    '{1'b0, 1'b1, 1'b1, 8'd10, 1'b1},
    '{1'b1, 1'b0, 1'b0, 8'd10, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'd40, 1'b1},
    '{1'b0, 1'b1, 1'b0, 8'd40, 1'b0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk_i) stat_rd_i = 1'b1;
    @(negedge clk_i) stat_rd_i = 1'b0;
  endtask

  task automatic align();
    if (!supply_hold_i) @(posedge sup_en_o);
    repeat (12) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    time t0, t1;
    int  e0;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 flag", edge_flag_o, 0);
    chk("R10 evt", wake_evt_o, 0);
    chk("R10 level", level_o, 1);
    chk("R10 sup_en", sup_en_o, 1);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);

    for (int i = 0; i < 6; i++) begin
      cont_mode_i   = VECS[i].cont;
      supply_hold_i = VECS[i].hold;
      wake_en_i     = VECS[i].en;
      repeat (10) @(negedge clk_i);
      clear_flag();
      e0 = evt_cnt;
      align();
      wake_ni = 1'b0;
      repeat (int'(VECS[i].low_len)) @(negedge clk_i);
      wake_ni = 1'b1;
      repeat (80) @(negedge clk_i);
      case (i)
        0: chk("R2 cont edge", edge_flag_o, VECS[i].exp_edge);
        1: chk("R3 cyclic miss", edge_flag_o, VECS[i].exp_edge);
        2: chk("R5 hold cont", edge_flag_o, VECS[i].exp_edge);
        3: chk("R7 disabled", edge_flag_o, VECS[i].exp_edge);
        4: chk("R3 cyclic hit", edge_flag_o, VECS[i].exp_edge);
        default: chk("R7 disabled hold", edge_flag_o, VECS[i].exp_edge);
      endcase
      chk("R9 evt count", evt_cnt - e0, {31'd0, VECS[i].exp_edge});
    end

    // R8 sticky then cleared
    cont_mode_i = 1'b1; supply_hold_i = 1'b0; wake_en_i = 1'b1;
    clear_flag();
    wake_ni = 1'b0;
    repeat (20) @(negedge clk_i);
    chk("R6 level low", level_o, 0);
    wake_ni = 1'b1;
    repeat (100) @(negedge clk_i);
    chk("R8 sticky", edge_flag_o, 1);
    clear_flag();
    chk("R8 cleared", edge_flag_o, 0);
    chk("R6 level high", level_o, 1);

    // R1 rising edge only
    wake_ni = 1'b0;
    repeat (20) @(negedge clk_i);
    clear_flag();
    wake_ni = 1'b1;
    repeat (30) @(negedge clk_i);
    chk("R1 rising ignored", edge_flag_o, 0);

    // R7 enabling while pin already low makes no edge
    wake_en_i = 1'b0;
    wake_ni = 1'b0;
    repeat (20) @(negedge clk_i);
    chk("R7 level tracks", level_o, 0);
    e0 = evt_cnt;
    wake_en_i = 1'b1;
    repeat (30) @(negedge clk_i);
    chk("R7 no false edge", edge_flag_o, 0);
    chk("R7 no false evt", evt_cnt - e0, 0);
    wake_ni = 1'b1;
    repeat (20) @(negedge clk_i);

    // R4 period and window length
    supply_hold_i = 1'b0;
    long_period_i = 1'b0;
    @(posedge sup_en_o); t0 = $time;
    @(negedge sup_en_o); t1 = $time;
    chk("R4 window len", int'((t1 - t0) / 5), ON_LEN);
    @(posedge sup_en_o); t1 = $time;
    chk("R4 short period", int'((t1 - t0) / 5), SHORT);
    long_period_i = 1'b1;
    @(posedge sup_en_o);
    @(posedge sup_en_o); t0 = $time;
    @(posedge sup_en_o); t1 = $time;
    chk("R4 long period", int'((t1 - t0) / 5), 2 * SHORT);

    // R5 held supply keeps sup_en high
    supply_hold_i = 1'b1;
    repeat (2 * SHORT) begin
      @(negedge clk_i);
      if (!sup_en_o) break;
    end
    chk("R5 sup_en held", sup_en_o, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule